// File: doc/BRIEF.md
# Load Visibility Controller

This block keeps two state bits for every slot of a load queue and refreshes them every clock according to a static defense scheme selected on a configuration input. The first bit, the fence hold, keeps a load from being issued to memory until the ordering condition of the scheme is met. The second bit, the expose-ready flag, marks a load whose speculative access may now be made visible or validated. The ordering conditions come in per slot from the surrounding pipeline. The block does not compute them, and it does not issue any memory request.

Five schemes are supported. In the baseline scheme, loads run freely and are always ready. The two fence schemes stall a load until either all older instructions or all older branches have committed. The two invisible schemes let loads run at once and mark them ready once either all older instructions have completed or all older branches have resolved. A counter tracks the loads that are ready and still owe a validation or expose. The counter rises when such a load first turns ready. It falls when one is squashed before its expose was sent, or when the issuing logic reports that it sent one.

Top module: `lvc_visibility_ctrl`

## Requirements
- R1: After a synchronous active-low reset every fence hold is 1, every expose-ready flag is 0, the pending count is 0 and both error outputs are 0.
- R2: Scheme code 0 (baseline): every slot reached by the walk has fence hold 0 and expose-ready 1 in the cycle after the inputs are applied.
- R3: Scheme codes 1 and 2 (fence): a walked slot gets expose-ready 1. Its fence hold becomes the inverse of older_committed under code 1 and the inverse of older_br_committed under code 2. The other ordering input has no effect.
- R4: Scheme codes 3 and 4 (invisible): a walked slot gets fence hold 0. Its expose-ready becomes older_completed under code 3 and older_br_resolved under code 4.
- R5: Under codes 3 or 4, the pending count rises by one for each walked slot whose expose-ready goes from 0 to 1 while needs_expose is 1. Under codes 0 to 2 no slot raises the count.
- R6: The walk starts at slot head and visits slots in increasing index order, wrapping modulo DEPTH. It stops after count slots or at the first slot whose occupied bit is 0. Slots not visited keep both bits.
- R7: A slot whose squash bit is 1 gets fence hold 1 and expose-ready 0, whatever else is applied that cycle. If it was ready, had needs_expose 1 and expose_sent 0, the pending count falls by one.
- R8: Under codes 3 or 4, a walked slot that was ready and whose condition is now 0 loses readiness and sets ready_loss_err. Once set, ready_loss_err stays 1 until reset.
- R9: Codes 5 to 7 are unsupported. In the next cycle every fence hold is 1, the expose-ready flags keep their values, the count is not raised and cfg_err is 1. Once set, cfg_err stays 1 until reset.
- R10: A pulse on vld_issue lowers the pending count by one. The count never goes below 0 and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scheme | input | 3 | Scheme code 0..4, others unsupported |
| head | input | $clog2(DEPTH) | Index of the oldest slot |
| count | input | $clog2(DEPTH+1) | Number of slots from head to walk |
| occupied | input | DEPTH | Slot holds a load |
| older_committed | input | DEPTH | All older instructions committed |
| older_br_committed | input | DEPTH | All older branches committed |
| older_completed | input | DEPTH | All older instructions completed |
| older_br_resolved | input | DEPTH | All older branches resolved |
| needs_expose | input | DEPTH | Load owes a later validation or expose |
| expose_sent | input | DEPTH | Expose already sent for the slot |
| squash | input | DEPTH | Slot removed this cycle |
| vld_issue | input | 1 | One pending validation was issued |
| fence_hold | output | DEPTH | Issue held back |
| expose_ready | output | DEPTH | Load may be made visible |
| pending_cnt | output | $clog2(DEPTH)+2 | Loads ready and owing an expose |
| ready_loss_err | output | 1 | Sticky: a ready slot lost readiness |
| cfg_err | output | 1 | Sticky: unsupported scheme seen |

## Verification
Each scheme runs a directed pattern in which only one of the four ordering inputs is set. This separates which condition each code really selects: for example, code 2 must ignore older_committed. The walk is tried with a wrapped head, a short count and a hole in the occupancy mask, which separates the two stop rules from the wrap-around. Squash is tried on a pending slot and on an already-sent slot, to show the decrement happens only for the first. Long random stretches under each code, with sparse squashes and issue pulses, are compared every cycle against a behavioural model. These catch interactions between the walk, squash priority and the counter clamp.

// File: rtl/lvc_pkg.sv
// Shared types for the load visibility controller.
// Assumes scheme codes are static during normal operation; the decode is
// purely combinational.
package lvc_pkg;

    typedef enum logic [2:0] {
        SCH_BASE      = 3'd0,
        SCH_FENCE_ALL = 3'd1,
        SCH_FENCE_BR  = 3'd2,
        SCH_INVIS_ALL = 3'd3,
        SCH_INVIS_BR  = 3'd4
    } scheme_e;

    typedef struct packed {
        logic supported;    // code is one of the five schemes
        logic exec_loads;   // loads may issue before the condition holds
        logic invisible;    // speculative loads use invisible accesses
        logic conservative; // wait on all older instructions, not branches
    } scheme_ctl_t;

    // Turn a scheme code into its three controls plus a validity bit.
    function automatic scheme_ctl_t decode_scheme(input logic [2:0] code);
        scheme_ctl_t c;
        case (code)
            SCH_BASE:      c = '{supported: 1'b1, exec_loads: 1'b1, invisible: 1'b0, conservative: 1'b0};
            SCH_FENCE_ALL: c = '{supported: 1'b1, exec_loads: 1'b0, invisible: 1'b0, conservative: 1'b1};
            SCH_FENCE_BR:  c = '{supported: 1'b1, exec_loads: 1'b0, invisible: 1'b0, conservative: 1'b0};
            SCH_INVIS_ALL: c = '{supported: 1'b1, exec_loads: 1'b1, invisible: 1'b1, conservative: 1'b1};
            SCH_INVIS_BR:  c = '{supported: 1'b1, exec_loads: 1'b1, invisible: 1'b1, conservative: 1'b0};
            default:       c = '{supported: 1'b0, exec_loads: 1'b0, invisible: 1'b0, conservative: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lvc_walk.sv
// Walk mask: marks the slots visited by the per-cycle update.
// Starts at head, advances with wrap at DEPTH, stops after count slots or
// at the first unoccupied slot. Assumes head < DEPTH and count <= DEPTH.
module lvc_walk #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [PW-1:0]    head,
    input  logic [CW-1:0]    count,
    input  logic [DEPTH-1:0] occupied,
    output logic [DEPTH-1:0] walked
);

    // Unrolled walk from the oldest slot; a stop condition kills the rest.
    always_comb begin
        logic        alive;
        logic [PW:0] pos;
        walked = '0;
        alive  = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            pos = {1'b0, head} + (PW+1)'(k);
            if (pos >= (PW+1)'(DEPTH)) begin
                pos = pos - (PW+1)'(DEPTH);
            end
            if (CW'(k) >= count || !occupied[pos[PW-1:0]]) begin
                alive = 1'b0;
            end
            walked[pos[PW-1:0]] = alive;
        end
    end

endmodule

// File: rtl/lvc_entry.sv
// One load-queue slot: holds the fence-hold and expose-ready bits and
// reports the events the pending counter and error flags need.
// Assumes kill (squash) overrides every other update in the same cycle.
module lvc_entry
    import lvc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  scheme_ctl_t ctl,
    input  logic        walked,
    input  logic        kill,
    input  logic        ok_all_commit,
    input  logic        ok_br_commit,
    input  logic        ok_all_done,
    input  logic        ok_br_resolved,
    input  logic        needs_exp,
    input  logic        exp_sent,
    output logic        hold_q,
    output logic        ready_q,
    output logic        inc_o,
    output logic        dec_o,
    output logic        loss_o
);

    logic hold_d;
    logic ready_d;
    logic fence_ok;
    logic vis_ok;

    // Pick the ordering condition each mode family waits on.
    always_comb begin
        fence_ok = ctl.conservative ? ok_all_commit : ok_br_commit;
        vis_ok   = ctl.conservative ? ok_all_done   : ok_br_resolved;
    end

    // Next-state and event logic for this slot.
    always_comb begin
        hold_d  = hold_q;
        ready_d = ready_q;
        inc_o   = 1'b0;
        dec_o   = 1'b0;
        loss_o  = 1'b0;
        if (kill) begin
            dec_o   = ready_q & needs_exp & ~exp_sent;
            hold_d  = 1'b1;
            ready_d = 1'b0;
        end else if (!ctl.supported) begin
            hold_d  = 1'b1;
        end else if (walked) begin
            if (!ctl.exec_loads) begin
                hold_d  = ~fence_ok;
                ready_d = 1'b1;
            end else if (ctl.invisible) begin
                hold_d  = 1'b0;
                ready_d = vis_ok;
                inc_o   = vis_ok & ~ready_q & needs_exp;
                loss_o  = ~vis_ok & ready_q;
            end else begin
                hold_d  = 1'b0;
                ready_d = 1'b1;
            end
        end
    end

    // State register with synchronous reset to the held, not-ready state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b1;
            ready_q <= 1'b0;
        end else begin
            hold_q  <= hold_d;
            ready_q <= ready_d;
        end
    end

endmodule

// File: rtl/lvc_pending.sv
// Pending-validation counter: adds slot increments, subtracts squash
// decrements and one issue pulse, clamped to [0, 2**NW-1].
// Assumes all events of a cycle are applied together.
module lvc_pending #(
    parameter int DEPTH = 8,
    parameter int NW    = $clog2(DEPTH) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] inc_vec,
    input  logic [DEPTH-1:0] dec_vec,
    input  logic             issue,
    output logic [NW-1:0]    cnt_q
);

    localparam int MAXV = (1 << NW) - 1;

    logic [NW-1:0] cnt_d;

    // Net change of the cycle with clamping at both ends.
    always_comb begin
        int n_inc;
        int n_dec;
        int tot;
        n_inc = 0;
        n_dec = 0;
        for (int i = 0; i < DEPTH; i++) begin
            n_inc = n_inc + int'(inc_vec[i]);
            n_dec = n_dec + int'(dec_vec[i]);
        end
        tot = int'(cnt_q) + n_inc - n_dec - int'(issue);
        if (tot < 0)    tot = 0;
        if (tot > MAXV) tot = MAXV;
        cnt_d = NW'(tot);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lvc_visibility_ctrl.sv
// Load visibility controller top: decodes the scheme, computes the walk
// mask, updates every slot, keeps the pending count and sticky errors.
// Assumes DEPTH >= 2 and that the ordering inputs are valid each cycle.
module lvc_visibility_ctrl
    import lvc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int NW    = $clog2(DEPTH) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       scheme,
    input  logic [PW-1:0]    head,
    input  logic [CW-1:0]    count,
    input  logic [DEPTH-1:0] occupied,
    input  logic [DEPTH-1:0] older_committed,
    input  logic [DEPTH-1:0] older_br_committed,
    input  logic [DEPTH-1:0] older_completed,
    input  logic [DEPTH-1:0] older_br_resolved,
    input  logic [DEPTH-1:0] needs_expose,
    input  logic [DEPTH-1:0] expose_sent,
    input  logic [DEPTH-1:0] squash,
    input  logic             vld_issue,
    output logic [DEPTH-1:0] fence_hold,
    output logic [DEPTH-1:0] expose_ready,
    output logic [NW-1:0]    pending_cnt,
    output logic             ready_loss_err,
    output logic             cfg_err
);

    scheme_ctl_t      ctl;
    logic [DEPTH-1:0] walked;
    logic [DEPTH-1:0] inc_vec;
    logic [DEPTH-1:0] dec_vec;
    logic [DEPTH-1:0] loss_vec;

    // Scheme code to controls.
    always_comb ctl = decode_scheme(scheme);

    lvc_walk #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_walk (
        .head     (head),
        .count    (count),
        .occupied (occupied),
        .walked   (walked)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lvc_entry u_slot (
            .clk            (clk),
            .rst_n          (rst_n),
            .ctl            (ctl),
            .walked         (walked[g]),
            .kill           (squash[g]),
            .ok_all_commit  (older_committed[g]),
            .ok_br_commit   (older_br_committed[g]),
            .ok_all_done    (older_completed[g]),
            .ok_br_resolved (older_br_resolved[g]),
            .needs_exp      (needs_expose[g]),
            .exp_sent       (expose_sent[g]),
            .hold_q         (fence_hold[g]),
            .ready_q        (expose_ready[g]),
            .inc_o          (inc_vec[g]),
            .dec_o          (dec_vec[g]),
            .loss_o         (loss_vec[g])
        );
    end

    lvc_pending #(.DEPTH(DEPTH), .NW(NW)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_vec (inc_vec),
        .dec_vec (dec_vec),
        .issue   (vld_issue),
        .cnt_q   (pending_cnt)
    );

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err        <= 1'b0;
            ready_loss_err <= 1'b0;
        end else begin
            cfg_err        <= cfg_err | ~ctl.supported;
            ready_loss_err <= ready_loss_err | (|loss_vec);
        end
    end

endmodule

// File: rtl/lvc_visibility_ctrl_chk.sv
// Checker for the load visibility controller, bound to every instance.
// Assumes the same parameters as the bound instance.
module lvc_visibility_ctrl_chk #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int NW    = $clog2(DEPTH) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       scheme,
    input logic [CW-1:0]    count,
    input logic [DEPTH-1:0] occupied,
    input logic [DEPTH-1:0] squash,
    input logic             vld_issue,
    input logic [DEPTH-1:0] fence_hold,
    input logic [DEPTH-1:0] expose_ready,
    input logic [NW-1:0]    pending_cnt,
    input logic             ready_loss_err,
    input logic             cfg_err
);

    logic full_walk;
    always_comb full_walk = (count == CW'(DEPTH)) && (occupied == '1) && (squash == '0);

    a_r9_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r9_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme > 3'd4) |=> ((fence_hold == '1) && cfg_err));

    a_r8_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_loss_err |=> ready_loss_err);

    a_r2_baseline_full: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme == 3'd0 && full_walk) |=> (fence_hold == '0 && expose_ready == '1));

    a_r4_invisible_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((scheme == 3'd3 || scheme == 3'd4) && full_walk) |=> (fence_hold == '0));

    a_r7_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (squash != '0) |=> (((fence_hold & $past(squash)) == $past(squash))
                            && ((expose_ready & $past(squash)) == '0)));

    a_r5_fence_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((scheme == 3'd1 || scheme == 3'd2) && squash == '0 && !vld_issue) |=> $stable(pending_cnt));

endmodule

bind lvc_visibility_ctrl lvc_visibility_ctrl_chk #(
    .DEPTH(DEPTH), .PW(PW), .CW(CW), .NW(NW)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scheme         (scheme),
    .count          (count),
    .occupied       (occupied),
    .squash         (squash),
    .vld_issue      (vld_issue),
    .fence_hold     (fence_hold),
    .expose_ready   (expose_ready),
    .pending_cnt    (pending_cnt),
    .ready_loss_err (ready_loss_err),
    .cfg_err        (cfg_err)
);

// File: tb/test_lvc_visibility_ctrl.sv
module test_lvc_visibility_ctrl;

    localparam int D  = 8;
    localparam int PW = $clog2(D);
    localparam int CW = $clog2(D + 1);
    localparam int NW = $clog2(D) + 2;
    localparam int MAXC = (1 << NW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    scheme = '0;
    logic [PW-1:0] head = '0;
    logic [CW-1:0] count = '0;
    logic [D-1:0]  occupied = '0, o_com = '0, o_brc = '0, o_cpl = '0, o_brr = '0;
    logic [D-1:0]  need = '0, sent = '0, squash = '0;
    logic          vld_issue = 1'b0;
    logic [D-1:0]  fence_hold, expose_ready;
    logic [NW-1:0] pending_cnt;
    logic          ready_loss_err, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state
    bit [D-1:0] m_fence, m_ready;
    int         m_cnt;
    bit         m_cfg, m_loss;

    always #2 clk = ~clk;

    lvc_visibility_ctrl #(.DEPTH(D)) i_lvc_visibility_ctrl (
        .clk(clk), .rst_n(rst_n), .scheme(scheme), .head(head), .count(count),
        .occupied(occupied), .older_committed(o_com), .older_br_committed(o_brc),
        .older_completed(o_cpl), .older_br_resolved(o_brr), .needs_expose(need),
        .expose_sent(sent), .squash(squash), .vld_issue(vld_issue),
        .fence_hold(fence_hold), .expose_ready(expose_ready), .pending_cnt(pending_cnt),
        .ready_loss_err(ready_loss_err), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Reference model: next state from current model state and inputs.
    task automatic model_step();
        bit [D-1:0] visit, nf, nr;
        bit ok, lost;
        int ninc, ndec, t;
        ok = (scheme <= 3'd4);
        visit = '0;
        for (int k = 0, alive = 1; k < D; k++) begin
            int idx;
            idx = (int'(head) + k) % D;
            if (k >= int'(count) || !occupied[idx]) alive = 0;
            visit[idx] = alive[0];
        end
        nf = m_fence; nr = m_ready; ninc = 0; ndec = 0; lost = 0;
        for (int i = 0; i < D; i++) begin
            if (squash[i]) begin
                if (m_ready[i] && need[i] && !sent[i]) ndec++;
                nf[i] = 1; nr[i] = 0;
            end else if (!ok) begin
                nf[i] = 1;
            end else if (visit[i]) begin
                case (scheme)
                    3'd0: begin nf[i] = 0; nr[i] = 1; end
                    3'd1: begin nf[i] = !o_com[i]; nr[i] = 1; end
                    3'd2: begin nf[i] = !o_brc[i]; nr[i] = 1; end
                    default: begin
                        bit c;
                        c = (scheme == 3'd3) ? o_cpl[i] : o_brr[i];
                        if (c && !m_ready[i] && need[i]) ninc++;
                        if (!c && m_ready[i]) lost = 1;
                        nr[i] = c; nf[i] = 0;
                    end
                endcase
            end
        end
        t = m_cnt + ninc - ndec - int'(vld_issue);
        if (t < 0) t = 0;
        if (t > MAXC) t = MAXC;
        m_cnt = t; m_fence = nf; m_ready = nr;
        m_cfg = m_cfg | !ok;
        m_loss = m_loss | lost;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " fence"}, fence_hold, m_fence);
        chk({tag, " ready"}, expose_ready, m_ready);
        chk({tag, " cnt"}, pending_cnt, m_cnt);
        chk({tag, " errs"}, {cfg_err, ready_loss_err}, {m_cfg, m_loss});
    endtask

    // One clock: update model, pass the edge, sample at the falling edge.
    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        squash = '0; vld_issue = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_fence = '1; m_ready = '0; m_cnt = 0; m_cfg = 0; m_loss = 0;
    endtask

    task automatic full_queue();
        head = '0; count = CW'(D); occupied = '1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 fence", fence_hold, {D{1'b1}});
        chk("R1 ready", expose_ready, 0);
        chk("R1 cnt", pending_cnt, 0);
        chk("R1 errs", {cfg_err, ready_loss_err}, 0);

        // R6 wrapped walk: head 6, three slots -> 6,7,0
        scheme = 3'd0; head = 3'd6; count = 4'd3; occupied = '1;
        cyc("R6 wrap");
        chk("R6 wrap ready", expose_ready, 8'b1100_0001);
        chk("R6 wrap fence", fence_hold, 8'b0011_1110);
        do_reset();
        occupied = 8'h7f;
        cyc("R6 hole");
        chk("R6 hole stops", expose_ready, 8'b0100_0000);

        // R2 baseline full queue
        do_reset();
        full_queue();
        cyc("R2 base");
        chk("R2 base ready", expose_ready, 8'hff);
        chk("R2 base fence", fence_hold, 8'h00);

        // R3 fence schemes select distinct conditions
        do_reset();
        full_queue(); scheme = 3'd1; o_com = 8'h0f; o_brc = 8'hf0;
        cyc("R3 fence all");
        chk("R3 code1 fence", fence_hold, 8'hf0);
        chk("R3 code1 ready", expose_ready, 8'hff);
        scheme = 3'd2; o_brc = 8'h33;
        cyc("R3 fence br");
        chk("R3 code2 fence", fence_hold, 8'hcc);
        chk("R5 fence no count", pending_cnt, 0);

        // R4 / R5 invisible scheme readiness and counting
        do_reset();
        full_queue(); scheme = 3'd3; o_com = '0; o_brc = '0;
        o_cpl = 8'h07; o_brr = 8'h00; need = 8'h03; sent = '0;
        cyc("R4 invis all");
        chk("R4 code3 ready", expose_ready, 8'h07);
        chk("R4 code3 fence", fence_hold, 8'h00);
        chk("R5 first ready count", pending_cnt, 2);
        cyc("R5 repeat");
        chk("R5 no recount", pending_cnt, 2);
        scheme = 3'd4; o_cpl = 8'h00; o_brr = 8'h07;
        cyc("R4 invis br");
        chk("R4 code4 ready", expose_ready, 8'h07);

        // R7 squash of a pending slot, then of a sent slot
        squash = 8'h01;
        cyc("R7 squash");
        chk("R7 cleared", {fence_hold[0], expose_ready[0]}, 2'b10);
        chk("R7 dec", pending_cnt, 1);
        squash = 8'h02; sent = 8'h02; occupied = 8'hfc; head = 3'd2; count = 4'd6;
        cyc("R7 squash sent");
        chk("R7 no dec when sent", pending_cnt, 1);
        squash = '0;

        // R10 issue pulse and clamp at zero
        vld_issue = 1'b1;
        cyc("R10 issue");
        chk("R10 dec", pending_cnt, 0);
        cyc("R10 clamp");
        chk("R10 clamp zero", pending_cnt, 0);
        vld_issue = 1'b0;

        // R8 readiness loss
        o_brr = 8'h00;
        cyc("R8 loss");
        chk("R8 loss flag", ready_loss_err, 1);
        chk("R8 ready cleared", expose_ready & 8'hfc, 0);
        o_brr = 8'hff;
        cyc("R8 sticky");
        chk("R8 loss sticky", ready_loss_err, 1);

        // random stretches under each supported scheme
        for (int s = 0; s < 5; s++) begin
            do_reset();
            scheme = 3'(s);
            for (int n = 0; n < 400; n++) begin
                head = PW'($urandom % D);
                count = CW'($urandom % (D + 1));
                occupied = ~D'($urandom & $urandom & $urandom);
                o_com = D'($urandom); o_brc = D'($urandom);
                o_cpl = D'($urandom | $urandom); o_brr = D'($urandom | $urandom);
                need = D'($urandom); sent = D'($urandom);
                squash = D'($urandom & $urandom & $urandom);
                vld_issue = (($urandom % 4) == 0);
                cyc(s == 0 ? "R2 rand" : (s < 3 ? "R3/R7 rand" : "R4/R5/R7/R10 rand"));
            end
        end
        squash = '0; vld_issue = 1'b0;

        // R9 unsupported code
        do_reset();
        full_queue(); scheme = 3'd0;
        cyc("R9 pre");
        scheme = 3'd6;
        cyc("R9 bad");
        chk("R9 cfg flag", cfg_err, 1);
        chk("R9 all held", fence_hold, 8'hff);
        chk("R9 ready kept", expose_ready, 8'hff);
        scheme = 3'd0;
        cyc("R9 sticky");
        chk("R9 cfg sticky", cfg_err, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule